// File: doc/BRIEF.md
# Variable-Length CAN Message Receive Buffer

This block is the receive store of a CAN controller. A receive path hands it one decoded message per cycle: format, RTR flag, DLC, identifier and up to eight data bytes. The block packs the message into its register byte layout and places it in a circular byte buffer, but only if the whole message fits in the free space. A message that does not fit is dropped whole, and an overrun flag is raised.

A bus host sees the oldest stored message through a read window. Offset k of the window returns the byte k places after the read start. When the host has finished with a message it issues a release. The block then reads the header byte at the read start, works out the length of that message from the header, and moves the read start past it. Messages therefore leave in variable-sized steps, not as fixed entries.

The block keeps a byte count and a message count. It also offers a clear-overrun command and a run-mode input. While run mode is low, writes and releases are ignored. A rising edge of run mode empties the buffer.

Top module: `rxmsg_fifo`

## Requirements
- R1: After reset the byte count, message count, pending flag and overrun flag are all 0, and every window offset reads 0x00.
- R2: An extended message is stored as follows. Header byte: bit 7 = 1, bit 6 = RTR, bits 5:4 = 0, bits 3:0 = DLC. Then ID[28:21], ID[20:13], ID[12:5], and {ID[4:0], 3'b000}. Then the data bytes, with data byte 0 taken from wr_data[7:0].
- R3: A standard message is stored as follows. Header byte: bit 7 = 0, bit 6 = RTR, bits 3:0 = DLC. Then ID[10:3] and {ID[2:0], 5'b00000}. Then the data bytes.
- R4: A data message stores min(DLC, 8) data bytes. An RTR message stores none. The byte count grows by 5 (extended) or 3 (standard), plus that number of data bytes.
- R5: A message whose length exceeds the free space (64 minus the byte count) is not stored. Both counts stay unchanged and the overrun flag is set.
- R6: A release with at least one stored message advances the read start, modulo 64, by the length decoded from the header byte at the read start, using the R4 rule. It lowers the byte count by that length and the message count by one.
- R7: A release while the message count is 0 has no effect.
- R8: The pending flag is 1 exactly when the message count is nonzero. It is cleared when the last message is released.
- R9: Window offsets 0 to 12 return the byte at (read start + offset) mod 64. Offsets 13 to 15 return 0x00.
- R10: Clear-overrun clears the overrun flag. If an overrun occurs in the same cycle, the flag stays set.
- R11: While run mode is low, writes and releases are ignored. In the cycle run mode rises, both counts and both pointers return to 0 and any write or release in that cycle is ignored.
- R12: When a write and a release arrive in the same cycle, the fit is judged on the byte count before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 1 = operating, 0 = reset mode |
| wr_valid | input | 1 | Message offered this cycle |
| wr_ext | input | 1 | Message uses the 29-bit identifier |
| wr_rtr | input | 1 | Message is a remote request |
| wr_dlc | input | 4 | Data length code |
| wr_id | input | 29 | Identifier, right-aligned (bits 10:0 for standard) |
| wr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_req | input | 1 | Release the oldest message |
| clr_ovr | input | 1 | Clear the overrun flag |
| rd_off | input | 4 | Window offset |
| rd_byte | output | 8 | Byte at the window offset |
| byte_cnt | output | 7 | Bytes held |
| msg_cnt | output | 5 | Messages held |
| rx_pend | output | 1 | At least one message held |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The hardest condition to reach from the ports is a release, or a window read, whose message straddles the wrap from byte 63 to byte 0. Overruns that occur in the same cycle as a release are similarly hard to reach. Both need the buffer to sit near full with mixed message lengths. The stimulus fills the buffer to exactly 52 bytes with 13-byte messages and forces a same-cycle write and release. It then runs several thousand random cycles, with write and release rates balanced so the fill level wanders across the whole range and the pointers wrap many times. It also drops run mode now and then.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef logic [7:0] byte_t;

   localparam int LEN_W    = 4;
   localparam int PACK_N   = 16;
   localparam int HDR_EXT  = 7;
   localparam int HDR_RTR  = 6;
   localparam int MAX_DATA = 8;

   // bytes a message occupies, from its format, RTR and DLC
   function automatic logic [LEN_W-1:0] frame_len(input logic ext, input logic rtr,
                                                  input logic [3:0] dlc);
      logic [LEN_W-1:0] nd;
      nd = rtr ? '0 : ((dlc > 4'(MAX_DATA)) ? 4'(MAX_DATA) : dlc);
      return (ext ? 4'd5 : 4'd3) + nd;
   endfunction
endpackage

// File: rtl/rxf_pack.sv
module rxf_pack
   import rxf_pkg::*;
(
   input  logic              ext,
   input  logic              rtr,
   input  logic [3:0]        dlc,
   input  logic [28:0]       id,
   input  logic [63:0]       data,
   output byte_t             bytes [PACK_N],
   output logic [LEN_W-1:0]  len
);
   logic [LEN_W-1:0] nd;
   logic [LEN_W-1:0] base;

   always_comb begin
      len  = frame_len(ext, rtr, dlc);
      base = ext ? 4'd5 : 4'd3;
      nd   = len - base;
      for (int j = 0; j < PACK_N; j++) bytes[j] = '0;
      bytes[0] = {ext, rtr, 2'b00, dlc};
      if (ext) begin
         bytes[1] = id[28:21];
         bytes[2] = id[20:13];
         bytes[3] = id[12:5];
         bytes[4] = {id[4:0], 3'b000};
      end else begin
         bytes[1] = id[10:3];
         bytes[2] = {id[2:0], 5'b00000};
      end
      for (int j = 0; j < MAX_DATA; j++) begin
         if (4'(j) < nd) bytes[base + 4'(j)] = data[8*j +: 8];
      end
   end
endmodule

// File: rtl/rxf_hdr_len.sv
module rxf_hdr_len
   import rxf_pkg::*;
(
   input  byte_t             hdr,
   output logic [LEN_W-1:0]  len
);
   assign len = frame_len(hdr[HDR_EXT], hdr[HDR_RTR], hdr[3:0]);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
   import rxf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int MSG_W = $clog2(DEPTH / 3 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_mode,
   input  logic              wr_valid,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              rel_req,
   input  logic [LEN_W-1:0]  rel_len,
   input  logic              clr_ovr,
   output logic              wr_accept,
   output logic [AW-1:0]     wr_ptr,
   output logic [AW-1:0]     rd_ptr,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic [MSG_W-1:0]  msg_cnt,
   output logic              rx_pend,
   output logic              ovr_flag
);
   logic run_q;
   logic run_rise;
   logic active;
   logic fits;
   logic rel_do;
   logic ovr_evt;
   logic [CNT_W:0] need;

   assign run_rise  = run_mode & ~run_q;
   assign active    = run_mode & ~run_rise;
   assign need      = {1'b0, byte_cnt} + (CNT_W+1)'(wr_len);
   assign fits      = need <= (CNT_W+1)'(DEPTH);
   assign wr_accept = active & wr_valid & fits;
   assign ovr_evt   = active & wr_valid & ~fits;
   assign rel_do    = active & rel_req & (msg_cnt != '0);
   assign rx_pend   = msg_cnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         byte_cnt <= '0;
         msg_cnt  <= '0;
      end else begin
         run_q <= run_mode;
         if (run_rise) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            byte_cnt <= '0;
            msg_cnt  <= '0;
         end else begin
            if (wr_accept) wr_ptr <= wr_ptr + AW'(wr_len);
            if (rel_do)    rd_ptr <= rd_ptr + AW'(rel_len);
            byte_cnt <= byte_cnt + (wr_accept ? CNT_W'(wr_len) : '0)
                                 - (rel_do ? CNT_W'(rel_len) : '0);
            msg_cnt  <= msg_cnt + MSG_W'(wr_accept) - MSG_W'(rel_do);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_flag <= 1'b0;
      else if (ovr_evt) ovr_flag <= 1'b1;
      else if (clr_ovr) ovr_flag <= 1'b0;
   end
endmodule

// File: rtl/rxmsg_fifo.sv
module rxmsg_fifo
   import rxf_pkg::*;
#(
   parameter  int DEPTH   = 64,
   parameter  int WIN_LEN = 13,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int MSG_W   = $clog2(DEPTH / 3 + 1),
   localparam int OFF_W   = $clog2(WIN_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_mode,
   input  logic              wr_valid,
   input  logic              wr_ext,
   input  logic              wr_rtr,
   input  logic [3:0]        wr_dlc,
   input  logic [28:0]       wr_id,
   input  logic [63:0]       wr_data,
   input  logic              rel_req,
   input  logic              clr_ovr,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [7:0]        rd_byte,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic [MSG_W-1:0]  msg_cnt,
   output logic              rx_pend,
   output logic              ovr_flag
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 16) begin : g_bad_depth
      $error("rxmsg_fifo: DEPTH must be a power of two of at least 16");
   end
   if (WIN_LEN < 13 || WIN_LEN > PACK_N) begin : g_bad_win
      $error("rxmsg_fifo: WIN_LEN must lie in 13..16");
   end

   byte_t             pk_bytes [PACK_N];
   logic [LEN_W-1:0]  pk_len;
   logic [LEN_W-1:0]  rel_len;
   logic              wr_accept;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   byte_t             mem [DEPTH];
   logic [AW-1:0]     ofs [DEPTH];
   logic [DEPTH-1:0]  wen;
   logic [AW-1:0]     rd_idx;

   rxf_pack u_pack (
      .ext   (wr_ext),
      .rtr   (wr_rtr),
      .dlc   (wr_dlc),
      .id    (wr_id),
      .data  (wr_data),
      .bytes (pk_bytes),
      .len   (pk_len)
   );

   rxf_hdr_len u_hlen (
      .hdr (mem[rd_ptr]),
      .len (rel_len)
   );

   rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_mode  (run_mode),
      .wr_valid  (wr_valid),
      .wr_len    (pk_len),
      .rel_req   (rel_req),
      .rel_len   (rel_len),
      .clr_ovr   (clr_ovr),
      .wr_accept (wr_accept),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .byte_cnt  (byte_cnt),
      .msg_cnt   (msg_cnt),
      .rx_pend   (rx_pend),
      .ovr_flag  (ovr_flag)
   );

   // per-cell distance from the write pointer selects the packed byte
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign ofs[i] = AW'(i) - wr_ptr;
      assign wen[i] = wr_accept && (ofs[i] < AW'(pk_len));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wen[i]) mem[i] <= pk_bytes[ofs[i][LEN_W-1:0]];
         end
      end
   end

   assign rd_idx  = rd_ptr + AW'(rd_off);
   assign rd_byte = (int'(rd_off) < WIN_LEN) ? mem[rd_idx] : 8'h00;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
   import rxf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int MSG_W = $clog2(DEPTH / 3 + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_mode,
   input logic              wr_valid,
   input logic [LEN_W-1:0]  wr_len,
   input logic              rel_req,
   input logic              clr_ovr,
   input logic [CNT_W-1:0]  byte_cnt,
   input logic [MSG_W-1:0]  msg_cnt,
   input logic              rx_pend,
   input logic              ovr_flag
);
   logic run_p;
   logic over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_p <= 1'b0;
      else        run_p <= run_mode;
   end

   assign over = run_mode && run_p && wr_valid && (int'(byte_cnt) + int'(wr_len) > DEPTH);

   // R5
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      over |=> ovr_flag && $stable(msg_cnt) || $past(rel_req));

   // R7
   empty_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode && run_p && rel_req && msg_cnt == '0 && !wr_valid) |=> msg_cnt == '0 && byte_cnt == '0);

   // R8
   pend_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_cnt == '0) |-> (byte_cnt == '0 && !rx_pend));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(byte_cnt) <= DEPTH);

   // R11
   enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode && !run_p) |=> (byte_cnt == '0 && msg_cnt == '0));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_mode |=> ($stable(byte_cnt) && $stable(msg_cnt)));

   // R10
   clr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ovr && !over) |=> !ovr_flag);
endmodule

bind rxmsg_fifo rxf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_mode (run_mode),
   .wr_valid (wr_valid),
   .wr_len   (pk_len),
   .rel_req  (rel_req),
   .clr_ovr  (clr_ovr),
   .byte_cnt (byte_cnt),
   .msg_cnt  (msg_cnt),
   .rx_pend  (rx_pend),
   .ovr_flag (ovr_flag)
);

// File: tb/tb_rxmsg_fifo.sv
`timescale 1ns/100ps
module tb_rxmsg_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_mode = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ext = 1'b0;
   logic        wr_rtr = 1'b0;
   logic [3:0]  wr_dlc = '0;
   logic [28:0] wr_id = '0;
   logic [63:0] wr_data = '0;
   logic        rel_req = 1'b0;
   logic        clr_ovr = 1'b0;
   logic [3:0]  rd_off = '0;
   logic [7:0]  rd_byte;
   logic [6:0]  byte_cnt;
   logic [4:0]  msg_cnt;
   logic        rx_pend;
   logic        ovr_flag;

   always #2.5 clk = ~clk;

   rxmsg_fifo dut (.*);

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] mb [64];
   int ms = 0, mw = 0, mc = 0, mm = 0;
   bit mo = 0, mrun = 0;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int flen(bit ext, bit rtr, logic [3:0] dlc);
      int nd = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
      return (ext ? 5 : 3) + nd;
   endfunction

   task automatic model_store(bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id, logic [63:0] d);
      logic [7:0] b [13];
      int n = flen(ext, rtr, dlc);
      int base = ext ? 5 : 3;
      for (int j = 0; j < 13; j++) b[j] = 8'h00;
      b[0] = {ext, rtr, 2'b00, dlc};
      if (ext) begin
         b[1] = 8'((id >> 21) & 29'hFF);
         b[2] = 8'((id >> 13) & 29'hFF);
         b[3] = 8'((id >> 5) & 29'hFF);
         b[4] = 8'((id & 29'h1F) << 3);
      end else begin
         b[1] = 8'((id >> 3) & 29'hFF);
         b[2] = 8'((id & 29'h7) << 5);
      end
      for (int j = 0; j < n - base; j++) b[base + j] = d[8*j +: 8];
      for (int j = 0; j < n; j++) mb[(mw + j) % 64] = b[j];
      mw = (mw + n) % 64;
   endtask

   task automatic check_all(string tag);
      chk({tag, " byte_cnt"}, int'(byte_cnt), mc);
      chk({tag, " msg_cnt"}, int'(msg_cnt), mm);
      chk({tag, " ovr_flag"}, int'(ovr_flag), int'(mo));
      chk({tag, " R8 rx_pend"}, int'(rx_pend), int'(mm != 0));
      for (int k = 0; k < 16; k++) begin
         rd_off = 4'(k);
         #0.1;
         chk({tag, " R9 window"}, int'(rd_byte), (k < 13) ? int'(mb[(ms + k) % 64]) : 0);
      end
   endtask

   // one cycle: inputs set now (after a falling edge), model follows the rising edge
   task automatic op(bit run, bit wv, bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id,
                     logic [63:0] d, bit rel, bit clr);
      bit rise, fits, rdo, oset;
      int wl, rl;
      run_mode = run; wr_valid = wv; wr_ext = ext; wr_rtr = rtr; wr_dlc = dlc;
      wr_id = id; wr_data = d; rel_req = rel; clr_ovr = clr;
      @(posedge clk);
      rise = run && !mrun;
      mrun = run;
      oset = 0;
      if (rise) begin
         ms = 0; mw = 0; mc = 0; mm = 0;
      end else if (run) begin
         wl = flen(ext, rtr, dlc);
         fits = (mc + wl) <= 64;
         rdo = rel && mm > 0;
         rl = rdo ? flen(mb[ms][7], mb[ms][6], mb[ms][3:0]) : 0;
         if (wv && fits) begin
            model_store(ext, rtr, dlc, id, d);
            mc += wl; mm++;
         end
         if (wv && !fits) oset = 1;
         if (rdo) begin
            ms = (ms + rl) % 64; mc -= rl; mm--;
         end
      end
      if (oset) mo = 1;
      else if (clr) mo = 0;
      @(negedge clk);
      wr_valid = 0; rel_req = 0; clr_ovr = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 64; i++) mb[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1 reset");

      // R11 writes ignored in reset mode
      op(0, 1, 1, 0, 4'd2, 29'h1, 64'h55, 0, 0);
      chk("R11 idle write", int'(byte_cnt), 0);
      op(1, 1, 0, 0, 4'd1, 29'h7, 64'h9, 0, 0);
      chk("R11 rise ignores write", int'(byte_cnt), 0);

      // R2 extended layout
      op(1, 1, 1, 0, 4'd3, 29'h12345678, 64'hCCBBAA, 0, 0);
      check_all("R2 ext");
      chk("R4 ext len", int'(byte_cnt), 8);
      rd_off = 0; #0.1 chk("R2 header", int'(rd_byte), 8'h83);
      rd_off = 1; #0.1 chk("R2 id hi", int'(rd_byte), 8'h91);
      rd_off = 2; #0.1 chk("R2 id b2", int'(rd_byte), 8'hA2);
      rd_off = 3; #0.1 chk("R2 id b3", int'(rd_byte), 8'hB3);
      rd_off = 4; #0.1 chk("R2 id lo", int'(rd_byte), 8'hC0);
      rd_off = 7; #0.1 chk("R2 data2", int'(rd_byte), 8'hCC);

      // R3 standard layout, lands after the 8-byte message
      op(1, 1, 0, 0, 4'd2, 29'h5A5, 64'h2211, 0, 0);
      check_all("R3 std");
      rd_off = 8;  #0.1 chk("R3 header", int'(rd_byte), 8'h02);
      rd_off = 9;  #0.1 chk("R3 id hi", int'(rd_byte), 8'hB4);
      rd_off = 10; #0.1 chk("R3 id lo", int'(rd_byte), 8'hA0);
      rd_off = 12; #0.1 chk("R3 data1", int'(rd_byte), 8'h22);

      // R4 RTR stores no data, DLC above 8 clamps
      op(1, 1, 1, 1, 4'd8, 29'h3, 64'hFFFF, 0, 0);
      chk("R4 rtr len", int'(byte_cnt), 18);
      op(1, 1, 0, 0, 4'd15, 29'h4, 64'h0807060504030201, 0, 0);
      chk("R4 dlc clamp", int'(byte_cnt), 29);
      check_all("R4 mix");

      // R6 releases
      for (int i = 0; i < 4; i++) begin
         op(1, 0, 0, 0, 0, 0, 0, 1, 0);
         check_all("R6 release");
      end
      chk("R8 pend clears", int'(rx_pend), 0);
      // R7 release when empty
      op(1, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R7 empty release", int'(byte_cnt), 0);
      check_all("R7 empty");

      // R5 fill with 13-byte messages
      for (int i = 0; i < 5; i++) op(1, 1, 1, 0, 4'd8, 29'(i), {8{8'(i)}}, 0, 0);
      chk("R5 count kept", int'(byte_cnt), 52);
      chk("R5 msgs kept", int'(msg_cnt), 4);
      chk("R5 overrun", int'(ovr_flag), 1);
      check_all("R5 full");
      // R12 write and release together, fit judged before release
      op(1, 1, 1, 0, 4'd8, 29'h9, 64'h1, 1, 1);
      chk("R12 dropped", int'(byte_cnt), 39);
      chk("R10 set wins", int'(ovr_flag), 1);
      op(1, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R10 cleared", int'(ovr_flag), 0);
      check_all("R12");

      // R11 run low holds, rising run empties
      op(0, 1, 0, 0, 4'd1, 29'h1, 64'h1, 1, 0);
      chk("R11 hold", int'(byte_cnt), 39);
      op(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R11 empty", int'(byte_cnt), 0);
      check_all("R11");

      // random mix, pointers wrap many times
      for (int i = 0; i < 4000; i++) begin
         bit run = ($urandom_range(0, 199) != 0);
         bit wv  = ($urandom_range(0, 99) < 60);
         bit rel = ($urandom_range(0, 99) < 45);
         bit clr = ($urandom_range(0, 99) < 10);
         op(run, wv, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            4'($urandom_range(0, 15)), 29'($urandom), {$urandom, $urandom}, rel, clr);
         check_all("R6 R9 R12 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule